// File: doc/BRIEF.md
# Privilege-Aware Virtual Address Segment Classifier

This block sits ahead of the translation lookaside buffer in a 32-bit memory pipeline. Each request carries a virtual address, the current privilege mode and the error-level status bit. The block sorts the address into one of five fixed regions by its top three bits. It then gives one of four answers: an identity mapping, a direct mapping that strips the region base, a hand-off to the TLB, or an address error. When the TLB is used, its physical address, permissions and result code pass through unchanged.

The TLB lookup is assumed combinational. Its answer must be presented on the TLB inputs in the same cycle as the request. All outputs are registered and appear one clock after the request. Between requests the outputs keep their last values, and the output valid flag is low.

Top module: `vseg_classifier`

## Requirements
- R1: While reset is high, and in the first cycle after it, out_valid, out_paddr, out_perm, out_use_tlb and out_code are all zero.
- R2: out_valid is the value in_valid had one clock earlier. When in_valid is low, out_paddr, out_perm, out_use_tlb and out_code keep their previous values.
- R3: An address below 0x80000000 with err_level low is sent to the TLB in any mode. out_use_tlb is 1, and out_paddr, out_perm and out_code equal tlb_paddr, tlb_perm and tlb_code from the request cycle.
- R4: An address below 0x80000000 with err_level high maps to itself in any mode. out_paddr equals the address, out_perm is 2'b11 (bit 1 write, bit 0 read), out_code is 0 (success) and out_use_tlb is 0.
- R5: An address from 0x80000000 to 0x9FFFFFFF in kernel mode gives out_paddr = address - 0x80000000, out_perm 2'b11, out_code 0 and out_use_tlb 0.
- R6: An address from 0xA0000000 to 0xBFFFFFFF in kernel mode gives out_paddr = address - 0xA0000000, out_perm 2'b11, out_code 0 and out_use_tlb 0.
- R7: An address from 0xC0000000 to 0xDFFFFFFF is passed through the TLB as in R3 in supervisor or kernel mode. In user mode it is an address error.
- R8: An address of 0xE0000000 or above is passed through the TLB as in R3 in kernel mode only. In supervisor or user mode it is an address error.
- R9: An address error gives out_code 1, out_paddr 0, out_perm 0 and out_use_tlb 0. Either direct-mapped kernel region (R5, R6) reached from supervisor or user mode is an address error.
- R10: priv_mode is decoded as 2'b00 kernel, 2'b01 supervisor, 2'b10 user, and 2'b11 is treated as user.
- R11: err_level has no effect on any address of 0x80000000 or above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| vaddr | input | 32 | Virtual address |
| priv_mode | input | 2 | Privilege mode (00 kernel, 01 supervisor, 1x user) |
| err_level | input | 1 | Error-level status bit |
| tlb_paddr | input | 32 | TLB physical address for this request |
| tlb_perm | input | 2 | TLB permissions (bit 1 write, bit 0 read) |
| tlb_code | input | 3 | TLB result code |
| out_valid | output | 1 | Result valid, one cycle after request |
| out_paddr | output | 32 | Physical address |
| out_perm | output | 2 | Permissions (bit 1 write, bit 0 read) |
| out_use_tlb | output | 1 | Result came from the TLB |
| out_code | output | 3 | Result code (0 success, 1 address error, else TLB code) |

## Verification
Each region boundary (0x00000000, 0x7FFFFFFF, 0x80000000, 0x9FFFFFFF, 0xA0000000, 0xBFFFFFFF, 0xC0000000, 0xDFFFFFFF, 0xE0000000, 0xFFFFFFFF) is tried in all four mode codes. These cases show whether the region edges and the access rules are decoded correctly. The same addresses are repeated with err_level high. This shows whether the identity map is confined to the user segment.

The TLB inputs carry values that differ from any direct-mapped result, so a forwarded answer cannot be confused with a computed one. Idle cycles placed between requests show whether the outputs hold. A long run of random addresses, modes and TLB values follows, and a behavioural model in the bench checks every cycle.

// File: rtl/vseg_pkg.sv
package vseg_pkg;

  typedef enum logic [1:0] {
    PRIV_KERNEL = 2'd0,
    PRIV_SUPER  = 2'd1,
    PRIV_USER   = 2'd2
  } priv_t;

  typedef enum logic [2:0] {
    REG_USEG    = 3'd0,
    REG_KDIRECT = 3'd1,
    REG_KNOCACH = 3'd2,
    REG_SMAPPED = 3'd3,
    REG_KMAPPED = 3'd4
  } region_t;

  typedef enum logic [1:0] {
    ACT_IDENTITY = 2'd0,
    ACT_DIRECT   = 2'd1,
    ACT_TLB      = 2'd2,
    ACT_FAULT    = 2'd3
  } action_t;

  localparam int PERM_W = 2;
  localparam logic [PERM_W-1:0] PERM_RW   = 2'b11;
  localparam logic [PERM_W-1:0] PERM_NONE = 2'b00;

endpackage

// File: rtl/vseg_priv_decode.sv
module vseg_priv_decode
  import vseg_pkg::*;
(
  input  logic [1:0] mode_code,
  output priv_t      priv
);
  always_comb begin
    unique case (mode_code)
      2'b00:   priv = PRIV_KERNEL;
      2'b01:   priv = PRIV_SUPER;
      default: priv = PRIV_USER;
    endcase
  end
endmodule

// File: rtl/vseg_region_decode.sv
module vseg_region_decode
  import vseg_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] vaddr,
  output region_t           region,
  output logic [ADDR_W-1:0] offset
);
  localparam int SEL_W = 3;
  localparam int OFF_W = ADDR_W - SEL_W;

  logic [SEL_W-1:0] sel;
  assign sel = vaddr[ADDR_W-1 -: SEL_W];

  // Region bases are aligned to the region size, so subtracting the base
  // is the same as clearing the selector bits.
  assign offset = {{SEL_W{1'b0}}, vaddr[OFF_W-1:0]};

  always_comb begin
    unique casez (sel)
      3'b0??:  region = REG_USEG;
      3'b100:  region = REG_KDIRECT;
      3'b101:  region = REG_KNOCACH;
      3'b110:  region = REG_SMAPPED;
      default: region = REG_KMAPPED;
    endcase
  end
endmodule

// File: rtl/vseg_access_check.sv
module vseg_access_check
  import vseg_pkg::*;
(
  input  region_t region,
  input  priv_t   priv,
  input  logic    err_level,
  output action_t action
);
  logic is_kernel;
  logic is_super_up;
  assign is_kernel   = (priv == PRIV_KERNEL);
  assign is_super_up = (priv != PRIV_USER);

  always_comb begin
    unique case (region)
      REG_USEG:    action = err_level   ? ACT_IDENTITY : ACT_TLB;
      REG_KDIRECT,
      REG_KNOCACH: action = is_kernel   ? ACT_DIRECT   : ACT_FAULT;
      REG_SMAPPED: action = is_super_up ? ACT_TLB      : ACT_FAULT;
      default:     action = is_kernel   ? ACT_TLB      : ACT_FAULT;
    endcase
  end
endmodule

// File: rtl/vseg_classifier.sv
module vseg_classifier
  import vseg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] vaddr,
  input  logic [1:0]        priv_mode,
  input  logic              err_level,
  input  logic [ADDR_W-1:0] tlb_paddr,
  input  logic [1:0]        tlb_perm,
  input  logic [CODE_W-1:0] tlb_code,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_paddr,
  output logic [1:0]        out_perm,
  output logic              out_use_tlb,
  output logic [CODE_W-1:0] out_code
);
  localparam logic [CODE_W-1:0] CODE_OK  = CODE_W'(0);
  localparam logic [CODE_W-1:0] CODE_BAD = CODE_W'(1);

  priv_t             priv;
  region_t           region;
  action_t           action;
  logic [ADDR_W-1:0] offset;

  vseg_priv_decode u_priv (
    .mode_code (priv_mode),
    .priv      (priv)
  );

  vseg_region_decode #(.ADDR_W(ADDR_W)) u_region (
    .vaddr  (vaddr),
    .region (region),
    .offset (offset)
  );

  vseg_access_check u_check (
    .region    (region),
    .priv      (priv),
    .err_level (err_level),
    .action    (action)
  );

  logic [ADDR_W-1:0] nx_paddr;
  logic [1:0]        nx_perm;
  logic              nx_use_tlb;
  logic [CODE_W-1:0] nx_code;

  always_comb begin
    unique case (action)
      ACT_IDENTITY: begin
        nx_paddr = vaddr;     nx_perm = PERM_RW;   nx_use_tlb = 1'b0; nx_code = CODE_OK;
      end
      ACT_DIRECT: begin
        nx_paddr = offset;    nx_perm = PERM_RW;   nx_use_tlb = 1'b0; nx_code = CODE_OK;
      end
      ACT_TLB: begin
        nx_paddr = tlb_paddr; nx_perm = tlb_perm;  nx_use_tlb = 1'b1; nx_code = tlb_code;
      end
      default: begin
        nx_paddr = '0;        nx_perm = PERM_NONE; nx_use_tlb = 1'b0; nx_code = CODE_BAD;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_paddr   <= '0;
      out_perm    <= '0;
      out_use_tlb <= 1'b0;
      out_code    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_paddr   <= nx_paddr;
        out_perm    <= nx_perm;
        out_use_tlb <= nx_use_tlb;
        out_code    <= nx_code;
      end
    end
  end
endmodule

// File: rtl/vseg_classifier_chk.sv
module vseg_classifier_chk #(
  parameter int ADDR_W = 32,
  parameter int CODE_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [ADDR_W-1:0] vaddr,
  input logic [1:0]        priv_mode,
  input logic              err_level,
  input logic [CODE_W-1:0] tlb_code,
  input logic              out_valid,
  input logic [ADDR_W-1:0] out_paddr,
  input logic [1:0]        out_perm,
  input logic              out_use_tlb,
  input logic [CODE_W-1:0] out_code
);
  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_idle_follows_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_paddr) && $stable(out_code)));
  assert_tlb_forward_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !err_level && !vaddr[ADDR_W-1])
      |=> (out_use_tlb && out_code == $past(tlb_code)));
  assert_identity_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && err_level && !vaddr[ADDR_W-1])
      |=> (out_paddr == $past(vaddr) && out_perm == 2'b11 && !out_use_tlb));
  assert_direct_strip_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && priv_mode == 2'b00 && vaddr[ADDR_W-1 -: 2] == 2'b10)
      |=> (out_paddr[ADDR_W-1 -: 3] == 3'b000 && !out_use_tlb));
  assert_kernel_only_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && priv_mode != 2'b00 && vaddr[ADDR_W-1 -: 3] == 3'b111)
      |=> (out_code == CODE_W'(1) && !out_use_tlb));
  assert_fault_clean_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_use_tlb && out_code != '0)
      |-> (out_paddr == '0 && out_perm == 2'b00));
endmodule

bind vseg_classifier vseg_classifier_chk #(.ADDR_W(ADDR_W), .CODE_W(CODE_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .vaddr       (vaddr),
  .priv_mode   (priv_mode),
  .err_level   (err_level),
  .tlb_code    (tlb_code),
  .out_valid   (out_valid),
  .out_paddr   (out_paddr),
  .out_perm    (out_perm),
  .out_use_tlb (out_use_tlb),
  .out_code    (out_code)
);

// File: tb/vseg_classifier_tb.sv
module vseg_classifier_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] vaddr = '0;
  logic [1:0]  priv_mode = '0;
  logic        err_level = 1'b0;
  logic [31:0] tlb_paddr = '0;
  logic [1:0]  tlb_perm = '0;
  logic [2:0]  tlb_code = '0;
  logic        out_valid;
  logic [31:0] out_paddr;
  logic [1:0]  out_perm;
  logic        out_use_tlb;
  logic [2:0]  out_code;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // expected state of the outputs
  logic        e_valid = 1'b0;
  logic [31:0] e_paddr = '0;
  logic [1:0]  e_perm = '0;
  logic        e_tlb = 1'b0;
  logic [2:0]  e_code = '0;
  string       e_tag = "R1";

  always #2 clk = ~clk;

  vseg_classifier u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .vaddr(vaddr),
    .priv_mode(priv_mode), .err_level(err_level), .tlb_paddr(tlb_paddr),
    .tlb_perm(tlb_perm), .tlb_code(tlb_code), .out_valid(out_valid),
    .out_paddr(out_paddr), .out_perm(out_perm), .out_use_tlb(out_use_tlb),
    .out_code(out_code)
  );

  task automatic model(input logic v, input logic [31:0] a, input logic [1:0] m,
                       input logic el, input logic [31:0] tp, input logic [1:0] tpm,
                       input logic [2:0] tc);
    int lvl; // 0 kernel, 1 supervisor, 2 user (R10)
    lvl = (m == 2'b00) ? 0 : (m == 2'b01) ? 1 : 2;
    e_valid = v;
    if (!v) begin e_tag = "R2"; return; end
    if (a < 32'h8000_0000) begin
      if (el) begin e_paddr = a; e_perm = 2'b11; e_tlb = 0; e_code = 0; e_tag = "R4"; end
      else    begin e_paddr = tp; e_perm = tpm; e_tlb = 1; e_code = tc; e_tag = "R3"; end
    end else if (a < 32'hA000_0000) begin
      if (lvl == 0) begin e_paddr = a - 32'h8000_0000; e_perm = 2'b11; e_tlb = 0; e_code = 0; e_tag = "R5"; end
      else begin e_paddr = 0; e_perm = 0; e_tlb = 0; e_code = 1; e_tag = "R9"; end
    end else if (a < 32'hC000_0000) begin
      if (lvl == 0) begin e_paddr = a - 32'hA000_0000; e_perm = 2'b11; e_tlb = 0; e_code = 0; e_tag = "R6"; end
      else begin e_paddr = 0; e_perm = 0; e_tlb = 0; e_code = 1; e_tag = "R9"; end
    end else if (a < 32'hE000_0000) begin
      e_tag = "R7";
      if (lvl != 2) begin e_paddr = tp; e_perm = tpm; e_tlb = 1; e_code = tc; end
      else begin e_paddr = 0; e_perm = 0; e_tlb = 0; e_code = 1; end
    end else begin
      e_tag = "R8";
      if (lvl == 0) begin e_paddr = tp; e_perm = tpm; e_tlb = 1; e_code = tc; end
      else begin e_paddr = 0; e_perm = 0; e_tlb = 0; e_code = 1; end
    end
    if (el && a >= 32'h8000_0000) e_tag = {e_tag, "/R11"};
  endtask

  task automatic compare(input string tag);
    n_tests++;
    if (out_valid !== e_valid || out_paddr !== e_paddr || out_perm !== e_perm ||
        out_use_tlb !== e_tlb || out_code !== e_code) begin
      n_fail++;
      $display("FAIL %s: got v=%0b pa=%h perm=%b tlb=%0b code=%0d, expected v=%0b pa=%h perm=%b tlb=%0b code=%0d",
               tag, out_valid, out_paddr, out_perm, out_use_tlb, out_code,
               e_valid, e_paddr, e_perm, e_tlb, e_code);
    end
  endtask

  task automatic step(input logic v, input logic [31:0] a, input logic [1:0] m,
                      input logic el, input logic [31:0] tp, input logic [1:0] tpm,
                      input logic [2:0] tc);
    @(negedge clk);
    in_valid = v; vaddr = a; priv_mode = m; err_level = el;
    tlb_paddr = tp; tlb_perm = tpm; tlb_code = tc;
    model(v, a, m, el, tp, tpm, tc);
    @(posedge clk); #1;
    compare(e_tag);
  endtask

  initial begin
    logic [31:0] edges [10];
    edges = '{32'h0000_0000, 32'h7FFF_FFFF, 32'h8000_0000, 32'h9FFF_FFFF,
              32'hA000_0000, 32'hBFFF_FFFF, 32'hC000_0000, 32'hDFFF_FFFF,
              32'hE000_0000, 32'hFFFF_FFFF};
    // R1: reset state
    repeat (3) @(posedge clk);
    #1; compare("R1");
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1; compare("R1");
    // boundaries in every mode code, err_level low then high (R3-R11)
    for (int el = 0; el < 2; el++)
      for (int m = 0; m < 4; m++)
        for (int i = 0; i < 10; i++) begin
          step(1'b1, edges[i], 2'(m), 1'(el), 32'h5A5A_0000 + 32'(i), 2'b01, 3'd3);
          if (i == 4) step(1'b0, 32'h1234_5678, 2'b00, 1'b0, '0, '0, '0); // R2 hold
        end
    // R3: TLB miss-style code forwarded for user segment in user mode code 11
    step(1'b1, 32'h0040_1000, 2'b11, 1'b0, 32'h0ABC_D000, 2'b00, 3'd2);
    step(1'b0, 32'hFFFF_0000, 2'b11, 1'b1, '1, '1, '1);
    step(1'b0, 32'h0, 2'b00, 1'b0, '0, '0, '0);
    // random traffic
    for (int k = 0; k < 3000; k++)
      step(($urandom % 4) != 0, $urandom, 2'($urandom), 1'($urandom),
           $urandom, 2'($urandom), 3'($urandom));
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule